// File: doc/BRIEF.md
# Truncated Tiled Fraction Multiplier

This block multiplies two 51-bit unsigned fractions and returns only the upper 53 bits of the 102-bit product. Each operand is cut into three 17-bit chunks, so the full product would need nine chunk-by-chunk partial products ("tiles"), each small enough for an 18×18 hard multiplier. The three tiles whose weight is lowest are never computed. Only six tiles are built, and the lost contribution is not compensated. The retained result is therefore a slightly low estimate of the exact top bits, with a small bounded error. That is the intended trade for a reciprocal or division datapath that does not round.

A mode input covers a datapath stage where the first operand's top chunk always holds 0x10000. In that mode the top chunk on the input is ignored. The three tiles that would use it become shifted copies of the second operand, so only three real tile multiplications remain. Operands, mode and valid are captured together. Partial products are registered in a first stage and summed in a second. A result therefore appears exactly two cycles after its request, at a rate of one per cycle.

Top module: `trunc_mul51`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and res_o is all zeros.
- R2: valid_o is high in exactly the cycles that follow, by two rising clock edges, a cycle in which valid_i was high.
- R3: res_o changes only at an edge where valid_o becomes or stays high; at any other edge it keeps its value.
- R4: With mode_i = 0, res_o equals bits 101 down to 49 of the sum of the tile products a_k·b_l·2^(17(k+l)) for k+l ≥ 2. Chunk k of an operand is bits 17k+16 down to 17k, so chunk 0 is bits 16:0.
- R5: res_o is never greater than bits 101:49 of the exact product of the effective operands.
- R6: Bits 101:49 of the exact product minus res_o is at most 9.
- R7: With mode_i = 1, bits 50:34 of a_i are ignored and treated as 0x10000. The result equals the mode-0 result for the same operands with that chunk set to 0x10000.
- R8: Back-to-back requests, including requests of mixed modes, each produce their own correct result in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request: operands and mode are captured this cycle |
| mode_i | input | 1 | 0 = general six-tile mode, 1 = top chunk of a_i forced to 0x10000 |
| a_i | input | 51 | First unsigned fraction operand |
| b_i | input | 51 | Second unsigned fraction operand |
| valid_o | output | 1 | res_o holds a new result this cycle |
| res_o | output | 53 | Upper 53 bits of the truncated product |

## Verification
A wrong or missing tile register, or a wrong tile weight, shows up at res_o on the second edge after the request. The error is usually far larger than the 9-unit window, so the per-cycle model comparison and the bound check both catch it on that result. A broken valid pipeline moves valid_o away from the two-edge slot at once. A register that captures without a request overwrites res_o in an idle cycle, which the hold comparison flags on that cycle. A bad constant-chunk path shows up only in mode 1 results. It is caught by comparing a mode-1 result with junk in the top chunk against a mode-0 result whose top chunk is 0x10000.

// File: rtl/trunc_mul_pkg.sv
package trunc_mul_pkg;
  typedef enum logic {
    MODE_GENERAL = 1'b0,
    MODE_TOPCONST = 1'b1
  } mul_mode_e;

  localparam int unsigned DEF_CHUNK_W  = 17;
  localparam int unsigned DEF_N_CHUNKS = 3;
  localparam int unsigned DEF_OUT_W    = 53;
endpackage

// File: rtl/tile_mul.sv
module tile_mul #(
  parameter int unsigned W = 17
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [2*W-1:0] p_o
);
  assign p_o = x_i * y_i;
endmodule

// File: rtl/tile_pp_stage.sv
module tile_pp_stage
  import trunc_mul_pkg::*;
#(
  parameter int unsigned CHUNK_W  = DEF_CHUNK_W,
  parameter int unsigned N_CHUNKS = DEF_N_CHUNKS,
  localparam int unsigned OP_W    = CHUNK_W * N_CHUNKS,
  localparam int unsigned PROD_W  = 2 * CHUNK_W,
  localparam int unsigned N_TILES = N_CHUNKS * N_CHUNKS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  mul_mode_e                 mode_i,
  input  logic [OP_W-1:0]           a_i,
  input  logic [OP_W-1:0]           b_i,
  output logic                      valid_o,
  output logic [N_TILES*PROD_W-1:0] tiles_o
);
  localparam int unsigned KEEP_MIN = N_CHUNKS - 1;
  localparam int unsigned TOP_IDX  = N_CHUNKS - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar gi = 0; gi < N_CHUNKS; gi++) begin : g_row
    for (genvar gj = 0; gj < N_CHUNKS; gj++) begin : g_col
      localparam int unsigned IDX = gi * N_CHUNKS + gj;
      if (gi + gj >= KEEP_MIN) begin : g_kept
        logic [PROD_W-1:0] p_d, p_mul, p_q;
        tile_mul #(.W(CHUNK_W)) i_tile (
          .x_i(a_i[gi*CHUNK_W +: CHUNK_W]),
          .y_i(b_i[gj*CHUNK_W +: CHUNK_W]),
          .p_o(p_mul)
        );
        if (gi == TOP_IDX) begin : g_top
          // constant top chunk 2^(W-1): tile collapses to a shift
          assign p_d = (mode_i == MODE_TOPCONST)
                     ? (PROD_W'(b_i[gj*CHUNK_W +: CHUNK_W]) << (CHUNK_W - 1))
                     : p_mul;
        end else begin : g_plain
          assign p_d = p_mul;
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      p_q <= '0;
          else if (valid_i) p_q <= p_d;
        end
        assign tiles_o[IDX*PROD_W +: PROD_W] = p_q;
      end else begin : g_dropped
        assign tiles_o[IDX*PROD_W +: PROD_W] = '0;
      end
    end
  end
endmodule

// File: rtl/tile_sum_stage.sv
module tile_sum_stage
  import trunc_mul_pkg::*;
#(
  parameter int unsigned CHUNK_W  = DEF_CHUNK_W,
  parameter int unsigned N_CHUNKS = DEF_N_CHUNKS,
  parameter int unsigned OUT_W    = DEF_OUT_W,
  localparam int unsigned OP_W    = CHUNK_W * N_CHUNKS,
  localparam int unsigned FULL_W  = 2 * OP_W,
  localparam int unsigned PROD_W  = 2 * CHUNK_W,
  localparam int unsigned N_TILES = N_CHUNKS * N_CHUNKS
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [N_TILES*PROD_W-1:0] tiles_i,
  output logic                      valid_o,
  output logic [OUT_W-1:0]          res_o
);
  logic [FULL_W-1:0] acc;
  logic              unused_lo;

  // dropped tiles arrive as zero, so the full grid is summed
  always_comb begin
    acc = '0;
    for (int i = 0; i < N_CHUNKS; i++) begin
      for (int j = 0; j < N_CHUNKS; j++) begin
        acc = acc + (FULL_W'(tiles_i[(i*N_CHUNKS+j)*PROD_W +: PROD_W])
                     << (CHUNK_W * (i + j)));
      end
    end
  end

  assign unused_lo = ^acc[FULL_W-OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= acc[FULL_W-1 -: OUT_W];
    end
  end
endmodule

// File: rtl/trunc_mul51.sv
module trunc_mul51
  import trunc_mul_pkg::*;
#(
  parameter int unsigned CHUNK_W  = DEF_CHUNK_W,
  parameter int unsigned N_CHUNKS = DEF_N_CHUNKS,
  parameter int unsigned OUT_W    = DEF_OUT_W,
  localparam int unsigned OP_W    = CHUNK_W * N_CHUNKS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             mode_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] res_o
);
  localparam int unsigned PROD_W  = 2 * CHUNK_W;
  localparam int unsigned N_TILES = N_CHUNKS * N_CHUNKS;

  logic                      pp_valid;
  logic [N_TILES*PROD_W-1:0] pp_tiles;
  mul_mode_e                 mode;

  assign mode = mul_mode_e'(mode_i);

  tile_pp_stage #(.CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS)) i_pp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .mode_i  (mode),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (pp_valid),
    .tiles_o (pp_tiles)
  );

  tile_sum_stage #(.CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .OUT_W(OUT_W)) i_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pp_valid),
    .tiles_i (pp_tiles),
    .valid_o (valid_o),
    .res_o   (res_o)
  );
endmodule

// File: rtl/trunc_mul51_chk.sv
module trunc_mul51_chk #(
  parameter int unsigned CHUNK_W  = 17,
  parameter int unsigned N_CHUNKS = 3,
  parameter int unsigned OUT_W    = 53,
  parameter int unsigned ERR_MAX  = 9,
  localparam int unsigned OP_W    = CHUNK_W * N_CHUNKS,
  localparam int unsigned FULL_W  = 2 * OP_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             mode_i,
  input logic [OP_W-1:0]  a_i,
  input logic [OP_W-1:0]  b_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] res_o
);
  localparam int unsigned LO_W = OP_W - CHUNK_W;

  logic [1:0]        seen;
  logic              v_d1, v_d2;
  logic [OP_W-1:0]   a_d1, a_d2, b_d1, b_d2;
  logic              m_d1, m_d2;
  logic [OP_W-1:0]   a_eff;
  logic [FULL_W-1:0] exact;
  logic [OUT_W-1:0]  exact_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen <= '0;
      {v_d1, v_d2, m_d1, m_d2} <= '0;
      {a_d1, a_d2, b_d1, b_d2} <= '0;
    end else begin
      if (seen != 2'd3) seen <= seen + 2'd1;
      v_d1 <= valid_i; v_d2 <= v_d1;
      m_d1 <= mode_i;  m_d2 <= m_d1;
      a_d1 <= a_i;     a_d2 <= a_d1;
      b_d1 <= b_i;     b_d2 <= b_d1;
    end
  end

  assign a_eff     = m_d2 ? {CHUNK_W'(1) << (CHUNK_W - 1), a_d2[LO_W-1:0]} : a_d2;
  assign exact     = FULL_W'(a_eff) * FULL_W'(b_d2);
  assign exact_top = exact[FULL_W-1 -: OUT_W];

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0));

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen >= 2'd2) |-> (valid_o == v_d2));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen >= 2'd1 && !valid_o) |-> $stable(res_o));

  // R5
  no_overshoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen >= 2'd2 && valid_o) |-> (res_o <= exact_top));

  // R6
  err_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen >= 2'd2 && valid_o && res_o <= exact_top) |->
      ((exact_top - res_o) <= OUT_W'(ERR_MAX)));
endmodule

bind trunc_mul51 trunc_mul51_chk #(
  .CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .OUT_W(OUT_W)
) i_trunc_mul51_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
  .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o)
);

// File: tb/test_trunc_mul51.sv
module test_trunc_mul51;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        mode = 1'b0;
  logic [50:0] a = '0, b = '0;
  logic        valid_o;
  logic [52:0] res_o;

  int n_vec = 0, n_fail = 0;
  bit done = 1'b0;

  trunc_mul51 i_trunc_mul51 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .a_i(a), .b_i(b), .valid_o(valid_o), .res_o(res_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] exact_prod(logic [50:0] x, logic [50:0] y, logic m);
    logic [127:0] xe;
    xe = m ? {77'b0, 17'h10000, x[33:0]} : {77'b0, x};
    return xe * {77'b0, y};
  endfunction

  function automatic logic [52:0] exact_top(logic [50:0] x, logic [50:0] y, logic m);
    logic [127:0] e;
    e = exact_prod(x, y, m);
    return e[101:49];
  endfunction

  // exact product minus the three lowest-weight tiles, then top bits
  function automatic logic [52:0] ref_trunc(logic [50:0] x, logic [50:0] y, logic m);
    logic [127:0] e, drop, kept, x0, x1, y0, y1;
    e    = exact_prod(x, y, m);
    x0   = {111'b0, x[16:0]};  x1 = {111'b0, x[33:17]};
    y0   = {111'b0, y[16:0]};  y1 = {111'b0, y[33:17]};
    drop = x0 * y0 + ((x0 * y1 + x1 * y0) << 17);
    kept = e - drop;
    return kept[101:49];
  endfunction

  task automatic check(input bit ok, input string req, input logic [52:0] act,
                       input logic [52:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle model
  logic        m_v1 = 1'b0, m_ov = 1'b0;
  logic [52:0] m_d1 = '0, m_od = '0;
  logic [52:0] top_q[$];
  bit          model_on = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v1 <= 1'b0; m_ov <= 1'b0; m_d1 <= '0; m_od <= '0;
      top_q.delete();
    end else begin
      m_v1 <= valid;
      if (valid) begin
        m_d1 <= ref_trunc(a, b, mode);
        top_q.push_back(exact_top(a, b, mode));
      end
      m_ov <= m_v1;
      if (m_v1) m_od <= m_d1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on && !done) begin
      check(valid_o == m_ov, "R2 valid", {52'b0, valid_o}, {52'b0, m_ov});
      if (m_ov) begin
        logic [52:0] et;
        check(res_o == m_od, "R4 R8 result", res_o, m_od);
        et = (top_q.size() > 0) ? top_q.pop_front() : '0;
        check(res_o <= et, "R5 overshoot", res_o, et);
        check((et - res_o) <= 53'd9, "R6 error window", res_o, et);
      end else begin
        check(res_o == m_od, "R3 hold", res_o, m_od);
      end
    end
  end

  task automatic run_one(input logic [50:0] x, input logic [50:0] y, input logic m,
                         output logic [52:0] r);
    @(negedge clk);
    a = x; b = y; mode = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; a = $urandom; b = $urandom; mode = $urandom;
    @(negedge clk);
    r = res_o;
    check(valid_o == 1'b1, "R2 single", {52'b0, valid_o}, 53'd1);
  endtask

  function automatic logic [50:0] rnd51();
    return {$urandom, $urandom};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [52:0] r, r2;
    logic [50:0] lo;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid", {52'b0, valid_o}, '0);
    check(res_o == '0, "R1 result", res_o, '0);
    rst_n = 1'b1;
    model_on = 1'b1;

    // directed corners (R4 R5 R6 via the model)
    run_one({51{1'b1}}, {51{1'b1}}, 1'b0, r);
    check(r == ref_trunc({51{1'b1}}, {51{1'b1}}, 1'b0), "R4 all ones", r,
          ref_trunc({51{1'b1}}, {51{1'b1}}, 1'b0));
    run_one(51'd1 << 50, 51'd1 << 50, 1'b0, r);
    check(r == 53'd1 << 51, "R4 power of two", r, 53'd1 << 51);
    run_one('0, {51{1'b1}}, 1'b0, r);
    check(r == '0, "R4 zero operand", r, '0);
    run_one({51{1'b1}}, {51{1'b1}}, 1'b1, r);
    check(r == ref_trunc({51{1'b1}}, {51{1'b1}}, 1'b1), "R7 all ones", r,
          ref_trunc({51{1'b1}}, {51{1'b1}}, 1'b1));

    // R7: mode 1 with junk top chunk equals mode 0 with 0x10000 top chunk
    for (int k = 0; k < 6; k++) begin
      lo = rnd51();
      b  = '0;
      run_one({17'h1abcd ^ 17'(k), lo[33:0]}, ~lo, 1'b1, r);
      run_one({17'h10000, lo[33:0]}, ~lo, 1'b0, r2);
      check(r == r2, "R7 top chunk ignored", r, r2);
    end

    // R8: back-to-back mixed stream with gaps (R3)
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      valid = ($urandom % 4) != 0;
      mode  = $urandom;
      a = rnd51(); b = rnd51();
      if (k % 37 == 0) a = {17'h10000, a[33:0]};
      if (k % 53 == 0) b = {51{1'b1}};
    end
    @(negedge clk);
    valid = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule